// File: doc/BRIEF.md
# E1 National Bit Inserter

This block supplies the values of the five national (Sa) bits that an E1 transmit framer places into timeslot 0 of each frame that does not carry the frame alignment word. An upstream frame counter announces every transmit bit with a one-cycle `bit_start` strobe. The strobe comes with the frame number within the 16-frame multiframe and the bit number within the frame. For each Sa position, the block hands the framer one bit through a one-cycle `ins_valid` strobe with `ins_bit`. The framer carries every other bit unchanged.

Three sources can supply the national bits. The first is the transmit serial data line. The second is an HDLC/LAPD controller, reached through a one-bit valid/ready handshake. The third is an external data link device on a two-wire overhead port. On the overhead port the block gates out one clock pulse for each Sa position enabled in a five-bit mask. The device changes its data after the rising edge. The block captures the data on the falling edge and inserts it at the same Sa position one non-alignment frame later. The source and the mask are picked up only at a multiframe boundary.

Handshake rules: the block raises `hdlc_ready` for one cycle and never waits. A bit moves only when `hdlc_valid` is high in that same cycle. Otherwise the block inserts 1 and the controller's bit stays with the controller. The framer cannot stall `ins_valid`.

Top module: `e1_natbit_inserter`

## Requirements
- R1: A synchronous active-high reset drives `oh_clk`, `ins_valid` and `hdlc_ready` low, clears all five captured overhead bits to 0 and selects the serial source with an all-zero mask. These settings hold until the first multiframe boundary.
- R2: `ins_valid` pulses only for zero-based bit numbers 3 to 7 (Sa4 to Sa8, mask bits 0 to 4) of frames with an odd frame number. It never pulses for any other bit or for even frames.
- R3: Source code 00 and source code 11 both select the serial source. At every Sa position `ins_bit` equals `ser_data` as sampled with `bit_start`, whatever the mask holds, and the overhead port stays idle.
- R4: With source code 10, `oh_clk` gives exactly one pulse for each Sa position whose mask bit is set. It gives no pulse for any other bit, and it gives no pulse under any other source.
- R5: Each `oh_clk` pulse rises in the cycle after `bit_start` and stays high for CLKS_PER_BIT/2 cycles. `oh_data` is captured at the clock edge where the pulse falls.
- R6: A bit captured at a given Sa position is inserted at that same Sa position in the next odd frame.
- R7: Under source code 10, a Sa position whose mask bit is clear is inserted as 1, and `ser_data` has no effect.
- R8: With source code 01, `hdlc_ready` is high in the `bit_start` cycle of each enabled Sa position and at no other time. The inserted bit is `hdlc_data` when `hdlc_valid` is high in that cycle. The inserted bit is 1 when `hdlc_valid` is low or when the position is disabled.
- R9: `cfg_src` and `cfg_mask` are loaded only on the `bit_start` of frame 0, bit 0. A change at any other time has no effect until that point.
- R10: `ins_valid` is high for exactly one cycle, in the cycle after `bit_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_start | input | 1 | One-cycle strobe at the start of each transmit bit |
| frame_num | input | $clog2(FRAMES_PER_MF) | Frame number within the multiframe |
| bit_num | input | $clog2(BITS_PER_FRAME) | Bit number within the frame, 0 = first bit of timeslot 0 |
| cfg_src | input | 2 | Source code: 00/11 serial, 01 HDLC, 10 overhead port |
| cfg_mask | input | 5 | Enable per Sa bit, bit 0 = Sa4 |
| ser_data | input | 1 | Transmit serial data bit |
| oh_clk | output | 1 | Gated clock to the data link device |
| oh_data | input | 1 | Serial data from the data link device |
| hdlc_valid | input | 1 | HDLC controller offers a bit |
| hdlc_data | input | 1 | Offered HDLC bit |
| hdlc_ready | output | 1 | Block takes an HDLC bit this cycle |
| ins_valid | output | 1 | Insert strobe to the framer |
| ins_bit | output | 1 | Value to insert |

## Verification
The bench goes after the capture pipeline. Right after reset the first overhead frame must insert zeros, and the bits fetched in that frame must appear only one odd frame later. A design that inserted freshly captured data at once, or that kept stale values after reset, would show the wrong pattern. A partial mask must give pulses only at the enabled positions and force the other positions to 1; a design that clocked every Sa bit or passed serial data through would fail there. The bench also runs both serial codes, starves the HDLC handshake at an enabled position, and changes the configuration mid-multiframe, where a design that loaded the configuration early would switch sources inside the multiframe.

// File: rtl/natb_pkg.sv
package natb_pkg;

  localparam int NSA          = 5;  // Sa4..Sa8
  localparam int SA_FIRST_BIT = 3;  // zero-based bit number of Sa4 in timeslot 0

  typedef enum logic [1:0] {
    PATH_SER  = 2'd0,
    PATH_HDLC = 2'd1,
    PATH_OH   = 2'd2
  } path_e;

  // Two codes land on the serial path.
  function automatic path_e decode_src(input logic [1:0] code);
    case (code)
      2'b01:   decode_src = PATH_HDLC;
      2'b10:   decode_src = PATH_OH;
      default: decode_src = PATH_SER;
    endcase
  endfunction

endpackage

// File: rtl/natb_pos_decode.sv
module natb_pos_decode
  import natb_pkg::*;
#(
  parameter int FW = 4,
  parameter int BW = 8
) (
  input  logic [FW-1:0]  frame_num,
  input  logic [BW-1:0]  bit_num,
  output logic [NSA-1:0] sa_onehot,
  output logic           sa_hit,
  output logic           mf_start
);

  // Odd frames carry the national bits; one comparator per Sa slot.
  for (genvar k = 0; k < NSA; k++) begin : g_slot
    assign sa_onehot[k] = frame_num[0] && (bit_num == BW'(SA_FIRST_BIT + k));
  end

  assign sa_hit   = |sa_onehot;
  assign mf_start = (frame_num == '0) && (bit_num == '0);

endmodule

// File: rtl/natb_cfg_latch.sv
module natb_cfg_latch
  import natb_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_start,
  input  logic           mf_start,
  input  logic [1:0]     cfg_src,
  input  logic [NSA-1:0] cfg_mask,
  output path_e          act_path,
  output logic [NSA-1:0] act_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_path <= PATH_SER;
      act_mask <= '0;
    end else if (bit_start && mf_start) begin
      act_path <= decode_src(cfg_src);
      act_mask <= cfg_mask;
    end
  end

endmodule

// File: rtl/natb_oh_port.sv
module natb_oh_port #(
  parameter int NSA          = 5,
  parameter int CLKS_PER_BIT = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NSA-1:0] sel,
  input  logic           oh_data,
  output logic           oh_clk,
  output logic [NSA-1:0] cap
);

  localparam int HALF = (CLKS_PER_BIT / 2 < 1) ? 1 : CLKS_PER_BIT / 2;
  localparam int HCW  = $clog2(HALF + 1);

  logic [HCW-1:0] hcnt;
  logic [NSA-1:0] sel_q;

  // High for HALF cycles, capture on the falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      oh_clk <= 1'b0;
      hcnt   <= '0;
      sel_q  <= '0;
      cap    <= '0;
    end else if (start) begin
      oh_clk <= 1'b1;
      hcnt   <= HCW'(HALF - 1);
      sel_q  <= sel;
    end else if (oh_clk) begin
      if (hcnt == '0) begin
        oh_clk <= 1'b0;
        cap    <= (cap & ~sel_q) | (sel_q & {NSA{oh_data}});
      end else begin
        hcnt <= hcnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/e1_natbit_inserter.sv
module e1_natbit_inserter
  import natb_pkg::*;
#(
  parameter int FRAMES_PER_MF  = 16,
  parameter int BITS_PER_FRAME = 256,
  parameter int CLKS_PER_BIT   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bit_start,
  input  logic [$clog2(FRAMES_PER_MF)-1:0]  frame_num,
  input  logic [$clog2(BITS_PER_FRAME)-1:0] bit_num,
  input  logic [1:0]                        cfg_src,
  input  logic [4:0]                        cfg_mask,
  input  logic                              ser_data,
  output logic                              oh_clk,
  input  logic                              oh_data,
  input  logic                              hdlc_valid,
  input  logic                              hdlc_data,
  output logic                              hdlc_ready,
  output logic                              ins_valid,
  output logic                              ins_bit
);

  localparam int FW = $clog2(FRAMES_PER_MF);
  localparam int BW = $clog2(BITS_PER_FRAME);

  logic [NSA-1:0] sa_onehot;
  logic           sa_hit;
  logic           mf_start;
  path_e          act_path;
  logic [NSA-1:0] act_mask;
  logic [NSA-1:0] cap;
  logic           sa_now;
  logic           sa_en;
  logic           oh_go;
  logic           nxt_bit;

  natb_pos_decode #(.FW(FW), .BW(BW)) u_pos (
    .frame_num (frame_num),
    .bit_num   (bit_num),
    .sa_onehot (sa_onehot),
    .sa_hit    (sa_hit),
    .mf_start  (mf_start)
  );

  natb_cfg_latch u_cfg (
    .clk       (clk),
    .rst       (rst),
    .bit_start (bit_start),
    .mf_start  (mf_start),
    .cfg_src   (cfg_src),
    .cfg_mask  (cfg_mask),
    .act_path  (act_path),
    .act_mask  (act_mask)
  );

  assign sa_now     = bit_start && sa_hit;
  assign sa_en      = |(act_mask & sa_onehot);
  assign oh_go      = sa_now && sa_en && (act_path == PATH_OH);
  assign hdlc_ready = sa_now && sa_en && (act_path == PATH_HDLC);

  natb_oh_port #(.NSA(NSA), .CLKS_PER_BIT(CLKS_PER_BIT)) u_oh (
    .clk     (clk),
    .rst     (rst),
    .start   (oh_go),
    .sel     (sa_onehot),
    .oh_data (oh_data),
    .oh_clk  (oh_clk),
    .cap     (cap)
  );

  always_comb begin
    case (act_path)
      PATH_HDLC: nxt_bit = (sa_en && hdlc_valid) ? hdlc_data : 1'b1;
      PATH_OH:   nxt_bit = sa_en ? |(cap & sa_onehot) : 1'b1;
      default:   nxt_bit = ser_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_valid <= 1'b0;
      ins_bit   <= 1'b1;
    end else begin
      ins_valid <= sa_now;
      ins_bit   <= sa_now ? nxt_bit : 1'b1;
    end
  end

endmodule

// File: rtl/e1_natbit_inserter_chk.sv
module e1_natbit_inserter_chk #(
  parameter int FW = 4,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_start,
  input logic [FW-1:0] frame_num,
  input logic [BW-1:0] bit_num,
  input logic          hdlc_valid,
  input logic          hdlc_data,
  input logic          hdlc_ready,
  input logic          oh_clk,
  input logic          ins_valid,
  input logic          ins_bit
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!oh_clk && !ins_valid));

  assert_insert_slot_R2: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> ($past(bit_start) && $past(frame_num[0]) &&
                   ($past(bit_num) >= BW'(3)) && ($past(bit_num) <= BW'(7))));

  assert_ohclk_with_insert_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(oh_clk) |-> ins_valid);

  assert_ohclk_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(oh_clk) |-> $past(bit_start));

  assert_ready_on_start_R8: assert property (@(posedge clk) disable iff (rst)
    hdlc_ready |-> bit_start);

  assert_hdlc_insert_R8: assert property (@(posedge clk) disable iff (rst)
    hdlc_ready |=> (ins_valid &&
                    (ins_bit == ($past(hdlc_valid) ? $past(hdlc_data) : 1'b1))));

endmodule

bind e1_natbit_inserter e1_natbit_inserter_chk #(.FW(FW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_start  (bit_start),
  .frame_num  (frame_num),
  .bit_num    (bit_num),
  .hdlc_valid (hdlc_valid),
  .hdlc_data  (hdlc_data),
  .hdlc_ready (hdlc_ready),
  .oh_clk     (oh_clk),
  .ins_valid  (ins_valid),
  .ins_bit    (ins_bit)
);

// File: tb/e1_natbit_inserter_tb.sv
module e1_natbit_inserter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 8;
  localparam int HALF       = CPB / 2;
  localparam int NB         = 10;  // bits driven per frame

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_start = 1'b0;
  logic [3:0] frame_num = '0;
  logic [7:0] bit_num = '0;
  logic [1:0] cfg_src = 2'b00;
  logic [4:0] cfg_mask = '0;
  logic       ser_data = 1'b0;
  logic       oh_clk;
  logic       oh_data = 1'b0;
  logic       hdlc_valid = 1'b0;
  logic       hdlc_data = 1'b0;
  logic       hdlc_ready;
  logic       ins_valid;
  logic       ins_bit;

  int checks = 0;
  int errors = 0;

  logic [7:0] dev_bits = '0;
  logic [7:0] ser_pat  = '0;
  logic [7:0] hv       = '0;
  logic [7:0] hd       = '0;
  logic       gv  [NB];
  logic       gb  [NB];
  logic       gv2 [NB];
  logic       rdy [NB];
  int         ohc [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  e1_natbit_inserter #(.CLKS_PER_BIT(CPB)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .bit_start  (bit_start),
    .frame_num  (frame_num),
    .bit_num    (bit_num),
    .cfg_src    (cfg_src),
    .cfg_mask   (cfg_mask),
    .ser_data   (ser_data),
    .oh_clk     (oh_clk),
    .oh_data    (oh_data),
    .hdlc_valid (hdlc_valid),
    .hdlc_data  (hdlc_data),
    .hdlc_ready (hdlc_ready),
    .ins_valid  (ins_valid),
    .ins_bit    (ins_bit)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic send_bit(input int f, input int b);
    @(negedge clk);
    bit_start  = 1'b1;
    frame_num  = 4'(f);
    bit_num    = 8'(b);
    ser_data   = ser_pat[b % 8];
    hdlc_valid = hv[b % 8];
    hdlc_data  = hd[b % 8];
    #1 rdy[b] = hdlc_ready;
    @(negedge clk);
    bit_start  = 1'b0;
    hdlc_valid = 1'b0;
    gv[b]  = ins_valid;
    gb[b]  = ins_bit;
    ohc[b] = 0;
    if (oh_clk) begin
      oh_data = dev_bits[b % 8];
      ohc[b]++;
    end
    for (int k = 1; k < CPB; k++) begin
      @(negedge clk);
      if (k == 1) gv2[b] = ins_valid;
      if (oh_clk) ohc[b]++;
    end
  endtask

  task automatic run_frame(input int f);
    for (int b = 0; b < NB; b++) send_bit(f, b);
  endtask

  // exp bits / oh / rdy are indexed k = 0..4 for Sa4..Sa8
  task automatic expect_frame(input string req, input int f, input logic [4:0] eb,
                              input logic [4:0] eoh, input logic [4:0] erdy);
    for (int b = 0; b < NB; b++) begin
      bit sa;
      sa = (f % 2 == 1) && (b >= 3) && (b <= 7);
      chk($sformatf("R2 valid f%0d b%0d", f, b), gv[b], sa ? 1 : 0);
      chk($sformatf("R10 one-cycle f%0d b%0d", f, b), gv2[b], 0);
      if (sa) begin
        chk($sformatf("%s bit f%0d b%0d", req, f, b), gb[b], eb[b-3]);
        chk($sformatf("R4 R5 ohclk f%0d b%0d", f, b), ohc[b], eoh[b-3] ? HALF : 0);
        chk($sformatf("R8 ready f%0d b%0d", f, b), rdy[b], erdy[b-3]);
      end else begin
        chk($sformatf("R4 no ohclk f%0d b%0d", f, b), ohc[b], 0);
        chk($sformatf("R8 no ready f%0d b%0d", f, b), rdy[b], 0);
      end
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oh_clk after reset", oh_clk, 0);
    chk("R1 ins_valid after reset", ins_valid, 0);
    chk("R1 hdlc_ready after reset", hdlc_ready, 0);
    // new config offered but no boundary yet: serial path still in use
    cfg_src  = 2'b10;
    cfg_mask = 5'b11111;
    ser_pat  = 8'b1001_0000;  // b3..b7 = 0,1,0,0,1
    run_frame(1);
    expect_frame("R1 serial default", 1, 5'b10010, 5'b00000, 5'b00000);
  endtask

  task automatic t_oh_basic;
    run_frame(0);
    expect_frame("R2 even frame", 0, 5'b00000, 5'b00000, 5'b00000);
    dev_bits = 8'b0110_1000;  // b3..b7 = 1,0,1,1,0
    run_frame(1);
    expect_frame("R1 cleared capture", 1, 5'b00000, 5'b11111, 5'b00000);
    run_frame(2);
    expect_frame("R2 even frame", 2, 5'b00000, 5'b00000, 5'b00000);
    dev_bits = '0;
    run_frame(3);
    expect_frame("R6 delayed insert", 3, 5'b01101, 5'b11111, 5'b00000);
  endtask

  task automatic t_oh_mask;
    cfg_mask = 5'b00101;
    ser_pat  = '0;
    run_frame(0);
    dev_bits = '0;
    run_frame(1);
    expect_frame("R7 masked to one", 1, 5'b11010, 5'b00101, 5'b00000);
    dev_bits = 8'b0000_1000;  // b3 = 1, b5 = 0
    run_frame(3);
    expect_frame("R7 masked to one", 3, 5'b11010, 5'b00101, 5'b00000);
    run_frame(5);
    expect_frame("R6 masked capture", 5, 5'b11011, 5'b00101, 5'b00000);
  endtask

  task automatic t_serial;
    cfg_src  = 2'b00;
    cfg_mask = 5'b00000;
    run_frame(0);
    ser_pat = 8'b0101_1000;  // b3..b7 = 1,1,0,1,0
    run_frame(1);
    expect_frame("R3 code 00", 1, 5'b01011, 5'b00000, 5'b00000);
    cfg_src  = 2'b11;
    cfg_mask = 5'b11111;
    run_frame(0);
    ser_pat = 8'b1010_0000;  // b3..b7 = 0,0,1,0,1
    run_frame(1);
    expect_frame("R3 code 11", 1, 5'b10100, 5'b00000, 5'b00000);
  endtask

  task automatic t_hdlc;
    cfg_src  = 2'b01;
    cfg_mask = 5'b11011;
    run_frame(0);
    hv = 8'b1011_1000;  // b3..b7 valid = 1,1,1,0,1
    hd = 8'b0011_0000;  // b3..b7 data  = 0,1,1,0,0
    ser_pat = 8'hFF;
    run_frame(1);
    expect_frame("R8 hdlc insert", 1, 5'b01110, 5'b00000, 5'b11011);
  endtask

  task automatic t_cfg_hold;
    cfg_src  = 2'b10;
    cfg_mask = 5'b11111;
    run_frame(3);
    expect_frame("R9 config held", 3, 5'b01110, 5'b00000, 5'b11011);
    hv = '0;
    run_frame(0);
    dev_bits = '0;
    run_frame(1);
    expect_frame("R9 config at boundary", 1, 5'b00001, 5'b11111, 5'b00000);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_oh_basic();
    t_oh_mask();
    t_serial();
    t_hdlc();
    t_cfg_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule